// File: doc/BRIEF.md
# Square-Wave Tone Generator Bank

This block is the tone section of a programmable sound generator. A shared prescaler divides the master clock into a slow tick: one master cycle in 16, or one in 2 when a parameter selects the low-ratio variant. Each tone channel holds a 10-bit half-period value supplied from outside. On every tick the channel runs a down-counter. When that counter reaches zero it reloads from the half-period and flips its output bit. The output is a square wave whose full period is twice the half-period, counted in ticks.

Each channel is a two-state machine. The states are `PH_LOW` and `PH_HIGH`, and they give the level of the output flip-flop. There is one transition in each direction, `PH_LOW -> PH_HIGH` and `PH_HIGH -> PH_LOW`. Both are taken on the reload event and nowhere else. A half-period of 0 or 1 forces the output high, whatever the state is, so software can play samples by changing the volume against a steady level. Each reload also raises a toggle-event output for one clock. The last channel's half-period is passed out on its own port as the rate source for the noise block. Volume and mixing belong to other blocks.

Top module: `tone_bank`

## Requirements
- R1: With `DIV_BY_TWO` = 0 the prescaler gives one tick every 16 master clocks. The first tick is acted on at the 16th rising edge after reset is released.
- R2: With `DIV_BY_TWO` = 1 the tick comes every 2 master clocks, and the first reload happens at the 2nd edge after reset.
- R3: During reset and until the first reload, every `wave_o` bit whose half-period is 2 or more reads 0, and every `toggle_o` bit reads 0.
- R4: For a half-period P of 2 or more, consecutive reloads of a channel are P ticks apart (P×16 master clocks by default), and `wave_o` flips at each one.
- R5: On a tick the counter steps down unless it is already zero. A reload happens only when the stepped value is zero, so a counter that sits at zero at reset reloads on the very first tick.
- R6: The half-period is sampled only at reload. A change made while the counter is running leaves the current interval as it is and applies from the next reload.
- R7: A half-period of 0 or 1 holds `wave_o` at 1 for that channel. Reloads then occur on every tick.
- R8: Bit c of `toggle_o` is high for exactly one master clock per reload of channel c, in the cycle that follows the reloading tick.
- R9: `noise_period_o` always equals the half-period field of the last channel, which is bits [29:20] in the default configuration.
- R10: The channels are independent. The half-period of one channel has no effect on the reload spacing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | 30 | Half-period per channel, channel c in bits [10c+9:10c] |
| wave_o | output | 3 | Square-wave output per channel |
| toggle_o | output | 3 | One-clock pulse per channel reload |
| tick_o | output | 1 | Prescaler tick |
| noise_period_o | output | 10 | Half-period of the last channel, passed to the noise block |

## Verification
The bench first times the first reload after reset, at both divider ratios. A prescaler that counted one cycle too many or too few, or a counter that did not reload from zero at start-up, would move that edge. It then changes a half-period in the middle of a count. A design that reloaded as soon as the value was written would cut the current interval short instead of finishing it. Half-periods of 0 and 1 are held while the output is watched for any low cycle, which a design without the forced-high override would show. The largest value, 1023, is run to catch a counter that wraps or drops bits.

// File: rtl/tone_pkg.sv
package tone_pkg;

    // Output flip-flop state of one tone channel
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Prescaler ratio chosen by the variant parameter
    function automatic int unsigned prescale_ratio(input bit div_by_two);
        return div_by_two ? 2 : 16;
    endfunction

    // Smallest half-period that produces a toggling output
    localparam int unsigned MIN_TOGGLE_PERIOD = 2;

endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler
    import tone_pkg::*;
#(
    parameter bit DIV_BY_TWO = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned RATIO = prescale_ratio(DIV_BY_TWO);
    localparam int unsigned CW    = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] phase_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
        end else if (phase_cnt == LAST) begin
            phase_cnt <= '0;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    always_comb begin
        tick_o = (phase_cnt == LAST);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1
    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> phase_cnt == '0); // R2

endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_pkg::*;
#(
    parameter int unsigned PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                wave_o,
    output logic                toggle_o
);
    localparam logic [PERIOD_W-1:0] DC_LIMIT = PERIOD_W'(MIN_TOGGLE_PERIOD);

    phase_e              state_q, state_d;
    logic [PERIOD_W-1:0] count_q, count_d;
    logic [PERIOD_W-1:0] stepped;
    logic                reload;
    logic                evt_q;

    // Step the counter and detect the zero-after-step reload event
    always_comb begin
        stepped = (count_q == '0) ? '0 : count_q - 1'b1;
        reload  = tick_i && (stepped == '0);
        if (reload) begin
            count_d = period_i;
        end else if (tick_i) begin
            count_d = stepped;
        end else begin
            count_d = count_q;
        end
    end

    // Next-state logic of the output flip-flop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (reload) state_d = PH_HIGH;
            PH_HIGH: if (reload) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    // State register, counter and event flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            count_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            evt_q   <= reload;
        end
    end

    // Output process: low half-periods hold the level high
    always_comb begin
        toggle_o = evt_q;
        if (period_i < DC_LIMIT) begin
            wave_o = 1'b1;
        end else begin
            unique case (state_q)
                PH_LOW:  wave_o = 1'b0;
                PH_HIGH: wave_o = 1'b1;
                default: wave_o = 1'b0;
            endcase
        end
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_q) && $stable(state_q)); // R5
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> count_q == $past(period_i)); // R6
    AST_FLIP_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> state_q != $past(state_q)); // R4
    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |=> !toggle_o); // R8

endmodule

// File: rtl/tone_bank.sv
module tone_bank
    import tone_pkg::*;
#(
    parameter int unsigned CH_COUNT   = 3,
    parameter int unsigned PERIOD_W   = 10,
    parameter bit          DIV_BY_TWO = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CH_COUNT*PERIOD_W-1:0] period_i,
    output logic [CH_COUNT-1:0]          wave_o,
    output logic [CH_COUNT-1:0]          toggle_o,
    output logic                         tick_o,
    output logic [PERIOD_W-1:0]          noise_period_o
);
    localparam int unsigned NOISE_SRC = CH_COUNT - 1;

    logic tick;

    tone_prescaler #(
        .DIV_BY_TWO(DIV_BY_TWO)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        tone_channel #(
            .PERIOD_W(PERIOD_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .period_i(period_i[c*PERIOD_W +: PERIOD_W]),
            .wave_o  (wave_o[c]),
            .toggle_o(toggle_o[c])
        );
    end

    always_comb begin
        tick_o         = tick;
        noise_period_o = period_i[NOISE_SRC*PERIOD_W +: PERIOD_W];
    end

    AST_EVENTS_FOLLOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_o != '0) |-> $past(tick)); // R10

endmodule

// File: tb/tone_bank_test.sv
module tone_bank_test;
    localparam int CH = 3;
    localparam int PW = 10;
    localparam int VEC_N = 5;
    localparam logic [PW-1:0] VP [VEC_N] = '{10'd2, 10'd3, 10'd7, 10'h0FE, 10'h3FF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CH*PW-1:0] period;
    logic [CH-1:0] wave_a, evt_a, wave_b, evt_b;
    logic tick_a, tick_b;
    logic [PW-1:0] noise_a, noise_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tone_bank #(.DIV_BY_TWO(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .period_i(period), .wave_o(wave_a),
        .toggle_o(evt_a), .tick_o(tick_a), .noise_period_o(noise_a));

    tone_bank #(.DIV_BY_TWO(1'b1)) uut2 (
        .clk(clk), .rst_n(rst_n), .period_i(period), .wave_o(wave_b),
        .toggle_o(evt_b), .tick_o(tick_b), .noise_period_o(noise_b));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_period(input int ch, input logic [PW-1:0] p);
        period[ch*PW +: PW] = p;
    endtask

    // Negedges until the next event on channel ch of instance b (0=uut,1=uut2)
    task automatic wait_evt(input bit b, input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!(b ? evt_b[ch] : evt_a[ch]));
    endtask

    initial begin
        int n;
        int first_a;
        int first_b;
        logic lvl;
        period = '0;
        set_period(0, 10'd3);
        set_period(1, 10'd5);
        set_period(2, 10'd9);
        repeat (3) @(negedge clk);
        // R3: reset state
        check("R3 wave during reset", int'(wave_a), 0);
        check("R3 toggle during reset", int'(evt_a | evt_b), 0);
        rst_n = 1'b1;
        first_a = 0;
        first_b = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) check("R3 wave before first reload", int'(wave_a[0]), 0);
            if (evt_a[0] && first_a == 0) first_a = k;
            if (evt_b[0] && first_b == 0) first_b = k;
            if (k == 16) check("R5 startup reload raises wave", int'(wave_a[0]), 1);
        end
        check("R1 first reload edge div16", first_a, 16);
        check("R2 first reload edge div2", first_b, 2);
        check("R9 noise period export", int'(noise_a), 9);

        // R2: divide-by-2 spacing, period 3 -> 6 clocks
        wait_evt(1'b1, 0, n);
        wait_evt(1'b1, 0, n);
        check("R2 div2 reload spacing", n, 6);

        // R4 vector table
        for (int v = 0; v < VEC_N; v++) begin
            set_period(0, VP[v]);
            wait_evt(1'b0, 0, n);
            lvl = wave_a[0];
            wait_evt(1'b0, 0, n);
            check($sformatf("R4 spacing P=%0d", VP[v]), n, int'(VP[v]) * 16);
            check($sformatf("R4 wave flips P=%0d", VP[v]), int'(wave_a[0]), int'(!lvl));
        end

        // R8: event is one clock wide
        wait_evt(1'b0, 0, n);
        @(negedge clk);
        check("R8 event width", int'(evt_a[0]), 0);

        // R6: mid-count change applies from next reload
        set_period(0, 10'd10);
        wait_evt(1'b0, 0, n);
        wait_evt(1'b0, 0, n);
        repeat (40) @(negedge clk);
        set_period(0, 10'd4);
        wait_evt(1'b0, 0, n);
        check("R6 running interval kept", n, 160 - 40);
        wait_evt(1'b0, 0, n);
        check("R6 new interval applied", n, 64);

        // R10: channel 1 unaffected by channel 0 changes
        wait_evt(1'b0, 1, n);
        wait_evt(1'b0, 1, n);
        check("R10 channel 1 spacing", n, 80);

        // R7: half-periods 0 and 1 hold the output high
        for (int p = 0; p < 2; p++) begin
            int lows;
            set_period(0, PW'(p));
            wait_evt(1'b0, 0, n);
            wait_evt(1'b0, 0, n);
            check($sformatf("R7 reload every tick P=%0d", p), n, 16);
            lows = 0;
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                if (!wave_a[0]) lows = lows + 1;
            end
            check($sformatf("R7 constant high P=%0d", p), lows, 0);
        end

        // R9: export follows the last channel
        set_period(2, 10'h2A5);
        #1;
        check("R9 noise period follows", int'(noise_a), 'h2A5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule